// File: doc/BRIEF.md
# Six-State Self-Correcting Sequence Counter

This block is a 3-bit synchronous counter that follows a fixed, non-binary cycle of six codes: 000, 001, 010, 100, 101, 110, and then back to 000. Each state bit is held in its own JK-style flip-flop, and all three share one clock. The next state is produced by JK input equations, not by an adder. The two codes outside the cycle, 011 and 111, each have a fixed successor inside the cycle. A counter that an upset drops into either of them is therefore back on the cycle after one enabled clock.

The counter advances only while its count enable is high. A synchronous active-high reset returns it to 000. A seed input writes any 3-bit code into the state register on the next clock, which lets a test or a fault-injection harness start the counter anywhere, unused codes included. A registered wrap flag marks each completed cycle. It is meant for chaining or for framing a six-phase timing sequence.

Top module: `modsix_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 000 and `wrap_o` becomes 0, whatever `seed_ld` and `cnt_en` are.
- R2: With `rst` and `seed_ld` low and `cnt_en` high, each clock moves the state one step along 000→001→010→100→101→110→000. `state_o[2]` is the most significant bit and `state_o[0]` the least significant bit.
- R3: The unused code 011, counted with enable high, moves to 100 on the next clock.
- R4: The unused code 111, counted with enable high, moves to 000 on the next clock.
- R5: With `rst`, `seed_ld` and `cnt_en` all low, the state keeps its value across the clock edge and `wrap_o` is 0 after that edge.
- R6: `wrap_o` is 1 for exactly the one cycle that follows an enabled counting step from 110 to 000. It is 0 after every other edge, including a reset or a seed load that produces 000.
- R7: With `rst` low and `seed_ld` high, the state takes `seed_val` on the next clock, whatever `cnt_en` is.
- R8: From any of the eight codes, counting with enable held high reaches 000 within at most six clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to 000 |
| cnt_en | input | 1 | Count enable; the state holds while it is low |
| seed_ld | input | 1 | Writes `seed_val` into the state on the next clock |
| seed_val | input | 3 | Code to write when `seed_ld` is high |
| state_o | output | 3 | Current state code (bit 2 is the MSB) |
| wrap_o | output | 1 | One-cycle flag that follows a 110→000 counting step |

## Verification
The hardest conditions to create are the two unused codes, 011 and 111, because no sequence of reset and enable ever leads to them. The stimulus reaches them with the seed load. Directed passes seed each of the eight codes, take a single enabled step, and then count on until 000 appears, comparing the number of clocks taken with a bench-computed distance. Random passes also mix seeds of unused codes with reset, hold and counting, so that recovery, wrap suppression and priority are all exercised next to each other.

// File: rtl/modsix_pkg.sv
`timescale 1ns/1ps
package modsix_pkg;
  localparam int STATE_W = 3;
  localparam int IDX_A   = 2;
  localparam int IDX_B   = 1;
  localparam int IDX_C   = 0;
  typedef logic [STATE_W-1:0] code_t;
  localparam code_t CODE_ZERO = 3'b000;
  localparam code_t CODE_LAST = 3'b110;
endpackage

// File: rtl/modsix_jk_bit.sv
`timescale 1ns/1ps
// One JK-style storage bit with synchronous reset, seed load and enable.
module modsix_jk_bit (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ld,
  input  logic ld_bit,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_nxt;

  always_comb q_nxt = (j & ~q) | (~k & q);

  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (ld)  q <= ld_bit;
    else if (en)  q <= q_nxt;
  end
endmodule

// File: rtl/modsix_steer.sv
`timescale 1ns/1ps
// JK input equations for the six-state cycle.
module modsix_steer
  import modsix_pkg::*;
(
  input  code_t cur,
  output code_t j_vec,
  output code_t k_vec
);
  always_comb begin
    // A toggles whenever B is set
    j_vec[IDX_A] = cur[IDX_B];
    k_vec[IDX_A] = cur[IDX_B];
    // B is set from C and always clears when it is set
    j_vec[IDX_B] = cur[IDX_C];
    k_vec[IDX_B] = 1'b1;
    // C is set while B is clear and always clears when it is set
    j_vec[IDX_C] = ~cur[IDX_B];
    k_vec[IDX_C] = 1'b1;
  end
endmodule

// File: rtl/modsix_wrap.sv
`timescale 1ns/1ps
// Registered wrap flag: high after a counting step leaves the last code.
module modsix_wrap
  import modsix_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  input  code_t cur,
  output logic  wrap_q
);
  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= step && (cur == CODE_LAST);
  end
endmodule

// File: rtl/modsix_counter.sv
`timescale 1ns/1ps
module modsix_counter
  import modsix_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               seed_ld,
  input  logic [STATE_W-1:0] seed_val,
  output logic [STATE_W-1:0] state_o,
  output logic               wrap_o
);
  code_t cur;
  code_t j_vec;
  code_t k_vec;
  logic  step;

  assign step = cnt_en & ~seed_ld;

  modsix_steer u_steer (
    .cur   (cur),
    .j_vec (j_vec),
    .k_vec (k_vec)
  );

  for (genvar g = 0; g < STATE_W; g++) begin : g_bit
    modsix_jk_bit u_bit (
      .clk    (clk),
      .rst    (rst),
      .en     (cnt_en),
      .ld     (seed_ld),
      .ld_bit (seed_val[g]),
      .j      (j_vec[g]),
      .k      (k_vec[g]),
      .q      (cur[g])
    );
  end

  modsix_wrap u_wrap (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .cur    (cur),
    .wrap_q (wrap_o)
  );

  assign state_o = cur;
endmodule

// File: rtl/modsix_counter_chk.sv
`timescale 1ns/1ps
module modsix_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       cnt_en,
  input logic       seed_ld,
  input logic [2:0] seed_val,
  input logic [2:0] state_o,
  input logic       wrap_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (state_o == 3'b000 && !wrap_o));

  a_r2_last_to_zero: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && cnt_en && state_o == 3'b110) |=> state_o == 3'b000);

  a_r3_unused_low: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && cnt_en && state_o == 3'b011) |=> state_o == 3'b100);

  a_r4_unused_high: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && cnt_en && state_o == 3'b111) |=> state_o == 3'b000);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && !cnt_en) |=> ($stable(state_o) && !wrap_o));

  a_r6_wrap_single: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);

  a_r6_wrap_at_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> state_o == 3'b000);

  a_r7_seed: assert property (@(posedge clk) disable iff (rst)
    seed_ld |=> (state_o == $past(seed_val) && !wrap_o));
endmodule

bind modsix_counter modsix_counter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_en   (cnt_en),
  .seed_ld  (seed_ld),
  .seed_val (seed_val),
  .state_o  (state_o),
  .wrap_o   (wrap_o)
);

// File: tb/modsix_counter_bench.sv
`timescale 1ns/1ps
module modsix_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       seed_ld = 1'b0;
  logic [2:0] seed_val = 3'b000;
  logic [2:0] state_o;
  logic       wrap_o;

  int checks = 0;
  int fails  = 0;
  logic [2:0] m_state = 3'b000;
  logic       m_wrap  = 1'b0;

  always #2 clk = ~clk;

  modsix_counter u_modsix_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .seed_ld(seed_ld),
    .seed_val(seed_val), .state_o(state_o), .wrap_o(wrap_o)
  );

  function automatic logic [2:0] ref_next(input logic [2:0] s);
    case (s)
      3'b000: ref_next = 3'b001;
      3'b001: ref_next = 3'b010;
      3'b010: ref_next = 3'b100;
      3'b011: ref_next = 3'b100;
      3'b100: ref_next = 3'b101;
      3'b101: ref_next = 3'b110;
      3'b110: ref_next = 3'b000;
      default: ref_next = 3'b000;
    endcase
  endfunction

  function automatic int dist_zero(input logic [2:0] s);
    logic [2:0] t = s;
    int n = 0;
    while (t != 3'b000 && n < 8) begin t = ref_next(t); n++; end
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs, clock once, update the model, compare both outputs.
  task automatic cycle(input logic r, input logic l, input logic [2:0] v,
                       input logic e, input string req);
    rst = r; seed_ld = l; seed_val = v; cnt_en = e;
    @(posedge clk);
    if (r)      begin m_state = 3'b000; m_wrap = 1'b0; end
    else if (l) begin m_state = v; m_wrap = 1'b0; end
    else if (e) begin m_wrap = (m_state == 3'b110); m_state = ref_next(m_state); end
    else        m_wrap = 1'b0;
    #1;
    check({req, " state"}, int'(state_o), int'(m_state));
    check({req, " wrap"}, int'(wrap_o), int'(m_wrap));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    cycle(1, 0, 3'b000, 0, "R1 reset");
    // R2 full cycle twice, wrap included (R6)
    for (int i = 0; i < 12; i++) cycle(0, 0, 3'b000, 1, "R2 R6 count");
    // R5 hold at several points
    cycle(0, 0, 3'b000, 0, "R5 hold");
    cycle(0, 0, 3'b000, 1, "R2 count");
    cycle(0, 0, 3'b000, 0, "R5 hold");
    // R1 reset beats seed and enable
    cycle(1, 1, 3'b101, 1, "R1 priority");
    // R3 / R4 unused codes
    cycle(0, 1, 3'b011, 0, "R7 seed");
    cycle(0, 0, 3'b000, 1, "R3 unused 011");
    cycle(0, 1, 3'b111, 1, "R7 seed over enable");
    cycle(0, 0, 3'b000, 1, "R4 unused 111");
    // R6 a seed of 000 after 110 raises no wrap
    cycle(0, 1, 3'b110, 0, "R7 seed");
    cycle(0, 1, 3'b000, 1, "R6 seed no wrap");
    // Every code as a start point: one step, then the recovery distance (R8)
    for (int c = 0; c < 8; c++) begin
      int n;
      cycle(0, 1, 3'(c), 0, "R7 seed");
      n = 0;
      while (state_o != 3'b000 && n < 7) begin
        cycle(0, 0, 3'b000, 1, "R8 step");
        n++;
      end
      check("R8 distance", n, dist_zero(3'(c)));
      check("R8 bound", int'(n <= 6), 1);
    end
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      logic r, l, e;
      logic [2:0] v;
      r = ($urandom % 25) == 0;
      l = ($urandom % 7) == 0;
      e = ($urandom % 4) != 0;
      v = 3'($urandom);
      cycle(r, l, v, e, r ? "R1 rand" : l ? "R7 rand" : e ? "R2 rand" : "R5 rand");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule